// File: doc/BRIEF.md
# Address Decoder with Boot Overlay

This block sits between an 8-bit processor bus with a 16-bit address and the memories and peripheral ports behind it. In each cycle it looks at the address and the read or write strobe. It raises at most one region select and presents the offset inside that region. It also returns the read data of the selected source in the same cycle. The regions are a boot ROM overlay, cartridge ROM, video RAM, external RAM, work RAM and its mirror window, an object-attribute page, I/O ports and a small high RAM. The high RAM is held inside the block. The other storage sits outside, behind the select, offset and read-data ports.

The block owns the boot-overlay flag. While the flag is set, the lowest page of the address space reads from the boot ROM instead of the cartridge. The flag clears when the last overlay byte is fetched or when the boot-control address is written. It then stays clear until the next reset. A write into the low part of video RAM also raises a tile-update strobe for the graphics side, which takes the address and data from the shared bus.

Top module: `mem_bus_router`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets boot_on to 1. With no strobe active, all selects, mem_we and tile_stb are 0, and bus_rdata is 0x00.
- R2: While boot_on is 1, a read of 0x0000..0x00FE asserts boot_sel with loc_offset = addr[7:0], and bus_rdata equals boot_rdata. Any other read below 0x8000 asserts rom_sel with loc_offset = addr[14:0], and bus_rdata equals rom_rdata.
- R3: A read of 0x00FE while boot_on is 1 still returns boot_rdata, and boot_on is 0 after that clock edge.
- R4: A write to 0xFF50 clears boot_on at that edge. Writes to 0xFF51..0xFF5F assert no select and leave boot_on unchanged.
- R5: Once boot_on is 0, it stays 0 until the next reset, and every read below 0x8000 goes to rom_sel.
- R6: A write anywhere in 0x0000..0x7FFF (0x2000 included) asserts no select and no mem_we.
- R7: 0x8000..0x9FFF asserts vid_sel with loc_offset = addr[12:0]. A write below 0x9800 also pulses tile_stb for that cycle.
- R8: 0xA000..0xBFFF asserts ext_sel, and 0xC000..0xDFFF asserts work_sel, each with loc_offset = addr[12:0]. 0xE000..0xFDFF also asserts work_sel with loc_offset = addr[12:0].
- R9: 0xFE00..0xFEFF asserts no select. Reads there return 0x00, and writes assert no mem_we.
- R10: 0xFF80..0xFFFF accesses an internal 128-byte RAM at index addr[6:0]. A byte written there reads back unchanged, and no external select is raised.
- R11: 0xFF00 asserts pad_sel with loc_offset 0. Reads of 0xFF40..0xFF7F assert gfx_sel with loc_offset = addr[7:0]. Writes there also assert gfx_sel, except in 0xFF50..0xFF5F.
- R12: Any other address in 0xFF01..0xFF7F asserts no select, reads as 0x00 and produces no mem_we.
- R13: mem_we is 1 exactly for writes that raise one of vid_sel, ext_sel, work_sel, pad_sel or gfx_sel. At most one select is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | Bus address |
| bus_wdata | input | 8 | Write data, also the data for tile updates |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_rdata | output | 8 | Read data for the current cycle |
| boot_rdata | input | 8 | Boot ROM byte at loc_offset |
| rom_rdata | input | 8 | Cartridge ROM byte at loc_offset |
| vid_rdata | input | 8 | Video RAM byte at loc_offset |
| ext_rdata | input | 8 | External RAM byte at loc_offset |
| work_rdata | input | 8 | Work RAM byte at loc_offset |
| pad_rdata | input | 8 | Joypad port read value |
| gfx_rdata | input | 8 | Graphics register port read value |
| boot_sel | output | 1 | Boot ROM select |
| rom_sel | output | 1 | Cartridge ROM select |
| vid_sel | output | 1 | Video RAM select |
| ext_sel | output | 1 | External RAM select |
| work_sel | output | 1 | Work RAM select (direct or mirror window) |
| pad_sel | output | 1 | Joypad port select |
| gfx_sel | output | 1 | Graphics register port select |
| mem_we | output | 1 | Write enable for the selected external region |
| loc_offset | output | 15 | Offset inside the selected region, 0 when none |
| tile_stb | output | 1 | Tile-update strobe |
| boot_on | output | 1 | Boot overlay flag |

## Verification
A wrong boot flag shows up on the very next read of the low page. The select moves between boot_sel and rom_sel, and bus_rdata changes its source in that same cycle. The bench therefore reads the low page right after each event that can clear the flag. A decode fault shows up combinationally in the same cycle as the access, as a wrong select, offset, mem_we or tile_stb. Faults in the high RAM appear when the location is read back after it was written. The mirror window is checked against the offset, so a work-RAM fault there is visible on the first access.

// File: rtl/bmr_pkg.sv
package bmr_pkg;

   typedef enum logic [3:0] {
      RG_NONE,
      RG_BOOT,
      RG_ROM,
      RG_VID,
      RG_EXT,
      RG_WORK,
      RG_PAD,
      RG_GFX,
      RG_HRAM,
      RG_BOOTCTL
   } region_e;

   // read-data source slots, in mux order
   localparam int SRC_BOOT = 0;
   localparam int SRC_ROM  = 1;
   localparam int SRC_VID  = 2;
   localparam int SRC_EXT  = 3;
   localparam int SRC_WORK = 4;
   localparam int SRC_PAD  = 5;
   localparam int SRC_GFX  = 6;
   localparam int SRC_HRAM = 7;
   localparam int NUM_SRC  = 8;

   function automatic region_e src_region(input int idx);
      case (idx)
         SRC_BOOT: return RG_BOOT;
         SRC_ROM:  return RG_ROM;
         SRC_VID:  return RG_VID;
         SRC_EXT:  return RG_EXT;
         SRC_WORK: return RG_WORK;
         SRC_PAD:  return RG_PAD;
         SRC_GFX:  return RG_GFX;
         default:  return RG_HRAM;
      endcase
   endfunction

endpackage

// File: rtl/bmr_decode.sv
module bmr_decode
   import bmr_pkg::*;
#(
   parameter int          ADDR_W     = 16,
   parameter int          OFF_W      = 15,
   parameter int          HRAM_AW    = 7,
   parameter logic [15:0] BOOT_LAST  = 16'h00FE,
   parameter logic [15:0] TILE_LIMIT = 16'h9800,
   parameter logic [7:0]  CTL_LO     = 8'h50
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              rd,
   input  logic              wr,
   input  logic              boot_on,
   output region_e           region,
   output logic [OFF_W-1:0]  offset,
   output logic              tile_stb,
   output logic              fetch_clr,
   output logic              ctl_clr
);

   localparam int WIN_W = 13;

   logic access;
   assign access = rd | wr;

   always_comb begin
      region = RG_NONE;
      offset = '0;
      if (access) begin
         case (addr[15:13])
            3'b000, 3'b001, 3'b010, 3'b011: begin
               if (!wr) begin
                  if (boot_on && (addr <= BOOT_LAST)) begin
                     region = RG_BOOT;
                     offset = OFF_W'(addr[7:0]);
                  end else begin
                     region = RG_ROM;
                     offset = addr[OFF_W-1:0];
                  end
               end
            end
            3'b100: begin
               region = RG_VID;
               offset = OFF_W'(addr[WIN_W-1:0]);
            end
            3'b101: begin
               region = RG_EXT;
               offset = OFF_W'(addr[WIN_W-1:0]);
            end
            3'b110: begin
               region = RG_WORK;
               offset = OFF_W'(addr[WIN_W-1:0]);
            end
            default: begin
               if (addr[12:9] != 4'hF) begin
                  // mirror window onto work RAM
                  region = RG_WORK;
                  offset = OFF_W'(addr[WIN_W-1:0]);
               end else if (!addr[8]) begin
                  region = RG_NONE;
               end else if (addr[7]) begin
                  region = RG_HRAM;
                  offset = OFF_W'(addr[HRAM_AW-1:0]);
               end else if (addr[6:0] == 7'd0) begin
                  region = RG_PAD;
               end else if (addr[6]) begin
                  if (wr && (addr[7:4] == CTL_LO[7:4])) begin
                     if (addr[3:0] == CTL_LO[3:0]) region = RG_BOOTCTL;
                  end else begin
                     region = RG_GFX;
                     offset = OFF_W'(addr[7:0]);
                  end
               end
            end
         endcase
      end
   end

   assign tile_stb  = wr && (region == RG_VID) && (addr < TILE_LIMIT);
   assign fetch_clr = rd && !wr && (region == RG_BOOT) && (addr == BOOT_LAST);
   assign ctl_clr   = (region == RG_BOOTCTL);

endmodule

// File: rtl/bmr_boot_flag.sv
module bmr_boot_flag (
   input  logic clk,
   input  logic rst,
   input  logic fetch_clr,
   input  logic ctl_clr,
   output logic boot_on
);

   always_ff @(posedge clk) begin
      if (rst)                      boot_on <= 1'b1;
      else if (fetch_clr | ctl_clr) boot_on <= 1'b0;
   end

   // R5: cleared flag never sets again without reset
   a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
      !boot_on |=> !boot_on);

endmodule

// File: rtl/bmr_hram.sv
module bmr_hram #(
   parameter int DATA_W = 8,
   parameter int AW     = 7
) (
   input  logic              clk,
   input  logic              we,
   input  logic [AW-1:0]     idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= wdata;
   end

   assign rdata = mem[idx];

endmodule

// File: rtl/bmr_rdata_mux.sv
module bmr_rdata_mux #(
   parameter int DATA_W = 8,
   parameter int NSRC   = 8
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        rd_en,
   input  logic [NSRC-1:0]             sel,
   input  logic [NSRC-1:0][DATA_W-1:0] src,
   output logic [DATA_W-1:0]           rdata
);

   logic [NSRC-1:0][DATA_W-1:0] masked;

   for (genvar g = 0; g < NSRC; g++) begin : g_mask
      assign masked[g] = (rd_en && sel[g]) ? src[g] : '0;
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NSRC; i++) rdata = rdata | masked[i];
   end

   // R13: decoder never presents two sources at once
   a_r13_sel_onehot: assert property (@(posedge clk) disable iff (rst)
      $onehot0(sel));

   // R1: no source and no read means a quiet data bus
   a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
      (sel == '0) |-> (rdata == '0));

endmodule

// File: rtl/mem_bus_router.sv
module mem_bus_router
   import bmr_pkg::*;
#(
   parameter int          ADDR_W     = 16,
   parameter int          DATA_W     = 8,
   parameter int          HRAM_AW    = 7,
   parameter logic [15:0] BOOT_LAST  = 16'h00FE,
   parameter logic [15:0] TILE_LIMIT = 16'h9800,
   parameter logic [7:0]  CTL_LO     = 8'h50
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [15:0]       bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_rd,
   input  logic              bus_wr,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] boot_rdata,
   input  logic [DATA_W-1:0] rom_rdata,
   input  logic [DATA_W-1:0] vid_rdata,
   input  logic [DATA_W-1:0] ext_rdata,
   input  logic [DATA_W-1:0] work_rdata,
   input  logic [DATA_W-1:0] pad_rdata,
   input  logic [DATA_W-1:0] gfx_rdata,
   output logic              boot_sel,
   output logic              rom_sel,
   output logic              vid_sel,
   output logic              ext_sel,
   output logic              work_sel,
   output logic              pad_sel,
   output logic              gfx_sel,
   output logic              mem_we,
   output logic [14:0]       loc_offset,
   output logic              tile_stb,
   output logic              boot_on
);

   localparam int OFF_W = ADDR_W - 1;

   // elaboration-time parameter checks
   if (ADDR_W != 16) begin : g_chk_addr
      $error("mem_bus_router: ADDR_W must be 16");
   end
   if (DATA_W < 1) begin : g_chk_data
      $error("mem_bus_router: DATA_W must be positive");
   end
   if (HRAM_AW < 1 || HRAM_AW > 7) begin : g_chk_hram
      $error("mem_bus_router: HRAM_AW must be 1..7");
   end
   if (BOOT_LAST > 16'h00FF) begin : g_chk_boot
      $error("mem_bus_router: BOOT_LAST must lie in the first page");
   end
   if (TILE_LIMIT < 16'h8000 || TILE_LIMIT > 16'hA000) begin : g_chk_tile
      $error("mem_bus_router: TILE_LIMIT must lie inside video RAM");
   end

   region_e                     region;
   logic [OFF_W-1:0]            offset;
   logic                        fetch_clr;
   logic                        ctl_clr;
   logic [NUM_SRC-1:0]          sel_vec;
   logic [NUM_SRC-1:0][DATA_W-1:0] src_data;
   logic [DATA_W-1:0]           hram_q;

   bmr_decode #(
      .ADDR_W     (ADDR_W),
      .OFF_W      (OFF_W),
      .HRAM_AW    (HRAM_AW),
      .BOOT_LAST  (BOOT_LAST),
      .TILE_LIMIT (TILE_LIMIT),
      .CTL_LO     (CTL_LO)
   ) u_dec (
      .addr      (bus_addr),
      .rd        (bus_rd),
      .wr        (bus_wr),
      .boot_on   (boot_on),
      .region    (region),
      .offset    (offset),
      .tile_stb  (tile_stb),
      .fetch_clr (fetch_clr),
      .ctl_clr   (ctl_clr)
   );

   bmr_boot_flag u_flag (
      .clk       (clk),
      .rst       (rst),
      .fetch_clr (fetch_clr),
      .ctl_clr   (ctl_clr),
      .boot_on   (boot_on)
   );

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_sel
      assign sel_vec[i] = (region == src_region(i));
   end

   bmr_hram #(
      .DATA_W (DATA_W),
      .AW     (HRAM_AW)
   ) u_hram (
      .clk   (clk),
      .we    (bus_wr && sel_vec[SRC_HRAM]),
      .idx   (bus_addr[HRAM_AW-1:0]),
      .wdata (bus_wdata),
      .rdata (hram_q)
   );

   assign src_data[SRC_BOOT] = boot_rdata;
   assign src_data[SRC_ROM]  = rom_rdata;
   assign src_data[SRC_VID]  = vid_rdata;
   assign src_data[SRC_EXT]  = ext_rdata;
   assign src_data[SRC_WORK] = work_rdata;
   assign src_data[SRC_PAD]  = pad_rdata;
   assign src_data[SRC_GFX]  = gfx_rdata;
   assign src_data[SRC_HRAM] = hram_q;

   bmr_rdata_mux #(
      .DATA_W (DATA_W),
      .NSRC   (NUM_SRC)
   ) u_mux (
      .clk   (clk),
      .rst   (rst),
      .rd_en (bus_rd && !bus_wr),
      .sel   (sel_vec),
      .src   (src_data),
      .rdata (bus_rdata)
   );

   assign boot_sel   = sel_vec[SRC_BOOT];
   assign rom_sel    = sel_vec[SRC_ROM];
   assign vid_sel    = sel_vec[SRC_VID];
   assign ext_sel    = sel_vec[SRC_EXT];
   assign work_sel   = sel_vec[SRC_WORK];
   assign pad_sel    = sel_vec[SRC_PAD];
   assign gfx_sel    = sel_vec[SRC_GFX];
   assign mem_we     = bus_wr && (|sel_vec[SRC_GFX:SRC_VID]);
   assign loc_offset = offset;

   // R2: boot select always returns the boot ROM byte
   a_r2_boot_data: assert property (@(posedge clk) disable iff (rst)
      boot_sel |-> (bus_rdata == boot_rdata));

   // R3: fetching the last overlay byte drops the flag
   a_r3_fetch_clears: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && !bus_wr && boot_on && bus_addr == BOOT_LAST) |=> !boot_on);

   // R4: boot-control write drops the flag
   a_r4_ctl_clears: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == {8'hFF, CTL_LO}) |=> !boot_on);

   // R4: control group writes reach no external region
   a_r4_ctl_no_we: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr[15:4] == {8'hFF, CTL_LO[7:4]}) |-> !mem_we);

   // R6: ROM area writes are inert
   a_r6_rom_write_quiet: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && !bus_addr[15]) |-> (!mem_we && !boot_sel && !rom_sel));

   // R7: tile strobe only with a video RAM write
   a_r7_tile_in_vram: assert property (@(posedge clk) disable iff (rst)
      tile_stb |-> (vid_sel && mem_we));

   // R9: object page reads zero and writes nowhere
   a_r9_oam_zero: assert property (@(posedge clk) disable iff (rst)
      ((bus_rd || bus_wr) && bus_addr[15:8] == 8'hFE) |-> (bus_rdata == '0 && !mem_we));

endmodule

// File: tb/mem_bus_router_test.sv
module mem_bus_router_test;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [15:0] addr = '0;
   logic [7:0]  wdata = '0;
   logic        rd = 1'b0;
   logic        wr = 1'b0;
   logic [7:0]  rdata;
   logic [7:0]  boot_rdata, rom_rdata, vid_rdata, ext_rdata, work_rdata, pad_rdata, gfx_rdata;
   logic        boot_sel, rom_sel, vid_sel, ext_sel, work_sel, pad_sel, gfx_sel;
   logic        mem_we, tile_stb, boot_on;
   logic [14:0] loc_offset;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   localparam logic [6:0] S_NONE = 7'h00, S_BOOT = 7'h01, S_ROM = 7'h02, S_VID = 7'h04,
                          S_EXT = 7'h08, S_WORK = 7'h10, S_PAD = 7'h20, S_GFX = 7'h40;

   always #2 clk = ~clk;

   // region models: each source returns a distinct function of its offset
   assign boot_rdata = loc_offset[7:0] ^ 8'hA5;
   assign rom_rdata  = loc_offset[7:0] ^ 8'h3C;
   assign vid_rdata  = loc_offset[7:0] ^ 8'h11;
   assign ext_rdata  = loc_offset[7:0] ^ 8'h22;
   assign work_rdata = loc_offset[7:0] ^ 8'h44;
   assign pad_rdata  = 8'hCF;
   assign gfx_rdata  = loc_offset[7:0] ^ 8'h99;

   wire [6:0] sels = {gfx_sel, pad_sel, work_sel, ext_sel, vid_sel, rom_sel, boot_sel};

   mem_bus_router uut (
      .clk(clk), .rst(rst), .bus_addr(addr), .bus_wdata(wdata), .bus_rd(rd), .bus_wr(wr),
      .bus_rdata(rdata), .boot_rdata(boot_rdata), .rom_rdata(rom_rdata), .vid_rdata(vid_rdata),
      .ext_rdata(ext_rdata), .work_rdata(work_rdata), .pad_rdata(pad_rdata), .gfx_rdata(gfx_rdata),
      .boot_sel(boot_sel), .rom_sel(rom_sel), .vid_sel(vid_sel), .ext_sel(ext_sel),
      .work_sel(work_sel), .pad_sel(pad_sel), .gfx_sel(gfx_sel), .mem_we(mem_we),
      .loc_offset(loc_offset), .tile_stb(tile_stb), .boot_on(boot_on)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; rd = 1'b0; wr = 1'b0;
      @(posedge clk); @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
   endtask

   // one bus cycle: drive at negedge, check combinational outputs, commit at posedge
   task automatic acc(input logic [15:0] a, input logic r, input logic w, input logic [7:0] wd,
                      input logic [6:0] esel, input logic [14:0] eoff, input logic [7:0] erd,
                      input logic et, input logic ewe, input string tag);
      @(negedge clk);
      addr = a; rd = r; wr = w; wdata = wd;
      #1;
      chk({tag, " select"}, 32'(sels), 32'(esel));
      if (esel != S_NONE) chk({tag, " offset"}, 32'(loc_offset), 32'(eoff));
      chk({tag, " rdata"}, 32'(rdata), 32'(erd));
      chk({tag, " tile_stb"}, 32'(tile_stb), 32'(et));
      chk({tag, " mem_we"}, 32'(mem_we), 32'(ewe));
      @(posedge clk);
      #1;
      rd = 1'b0; wr = 1'b0;
   endtask

   task automatic flag_is(input logic e, input string tag);
      chk({tag, " boot_on"}, 32'(boot_on), 32'(e));
   endtask

   task automatic t_reset_state();
      do_reset();
      #1;
      flag_is(1'b1, "R1 after reset");
      chk("R1 idle select", 32'(sels), 32'(S_NONE));
      chk("R1 idle rdata", 32'(rdata), 32'h0);
      chk("R13 idle mem_we", 32'(mem_we), 32'h0);
   endtask

   task automatic t_overlay();
      acc(16'h0010, 1, 0, 0, S_BOOT, 15'h0010, 8'h10 ^ 8'hA5, 0, 0, "R2 boot read");
      acc(16'h00FF, 1, 0, 0, S_ROM, 15'h00FF, 8'hFF ^ 8'h3C, 0, 0, "R2 past overlay");
      acc(16'h4123, 1, 0, 0, S_ROM, 15'h4123, 8'h23 ^ 8'h3C, 0, 0, "R2 upper rom");
      flag_is(1'b1, "R2 flag kept");
   endtask

   task automatic t_rom_writes();
      acc(16'h2000, 0, 1, 8'h01, S_NONE, 0, 8'h00, 0, 0, "R6 bank stub write");
      acc(16'h0100, 0, 1, 8'h02, S_NONE, 0, 8'h00, 0, 0, "R6 rom0 write");
      acc(16'h7FFF, 0, 1, 8'h03, S_NONE, 0, 8'h00, 0, 0, "R6 rom1 write");
      acc(16'h00FE, 0, 1, 8'h04, S_NONE, 0, 8'h00, 0, 0, "R6 write at overlay end");
      flag_is(1'b1, "R6 flag kept");
      acc(16'hFF51, 0, 1, 8'h01, S_NONE, 0, 8'h00, 0, 0, "R4 neighbour write");
      acc(16'hFF5F, 0, 1, 8'h01, S_NONE, 0, 8'h00, 0, 0, "R4 group top write");
      flag_is(1'b1, "R4 neighbour leaves flag");
   endtask

   task automatic t_fetch_clear();
      acc(16'h00FE, 1, 0, 0, S_BOOT, 15'h00FE, 8'hFE ^ 8'hA5, 0, 0, "R3 last overlay byte");
      flag_is(1'b0, "R3 cleared");
      acc(16'h0010, 1, 0, 0, S_ROM, 15'h0010, 8'h10 ^ 8'h3C, 0, 0, "R5 rom after clear");
      acc(16'hFF51, 0, 1, 8'h00, S_NONE, 0, 8'h00, 0, 0, "R5 other write");
      acc(16'h00FE, 1, 0, 0, S_ROM, 15'h00FE, 8'hFE ^ 8'h3C, 0, 0, "R5 end byte from rom");
      repeat (3) @(posedge clk);
      #1;
      flag_is(1'b0, "R5 stays clear");
   endtask

   task automatic t_ctl_clear();
      do_reset();
      #1;
      flag_is(1'b1, "R1 second reset");
      acc(16'hFF50, 0, 1, 8'h01, S_NONE, 0, 8'h00, 0, 0, "R4 control write");
      flag_is(1'b0, "R4 cleared");
      acc(16'h0005, 1, 0, 0, S_ROM, 15'h0005, 8'h05 ^ 8'h3C, 0, 0, "R5 rom after control");
   endtask

   task automatic t_video();
      acc(16'h8123, 0, 1, 8'h77, S_VID, 15'h0123, 8'h00, 1, 1, "R7 tile write");
      acc(16'h97FF, 0, 1, 8'h78, S_VID, 15'h17FF, 8'h00, 1, 1, "R7 tile top write");
      acc(16'h9800, 0, 1, 8'h79, S_VID, 15'h1800, 8'h00, 0, 1, "R7 map write");
      acc(16'h8123, 1, 0, 0, S_VID, 15'h0123, 8'h23 ^ 8'h11, 0, 0, "R7 read no strobe");
      acc(16'h9FFF, 1, 0, 0, S_VID, 15'h1FFF, 8'hFF ^ 8'h11, 0, 0, "R7 top read");
   endtask

   task automatic t_rams();
      acc(16'hA005, 1, 0, 0, S_EXT, 15'h0005, 8'h05 ^ 8'h22, 0, 0, "R8 ext read");
      acc(16'hBFFF, 0, 1, 8'h5, S_EXT, 15'h1FFF, 8'h00, 0, 1, "R8 ext write");
      acc(16'hC100, 1, 0, 0, S_WORK, 15'h0100, 8'h00 ^ 8'h44, 0, 0, "R8 work read");
      acc(16'hD000, 0, 1, 8'h6, S_WORK, 15'h1000, 8'h00, 0, 1, "R8 work write");
      acc(16'hE100, 1, 0, 0, S_WORK, 15'h0100, 8'h00 ^ 8'h44, 0, 0, "R8 mirror read");
      acc(16'hFDFF, 0, 1, 8'h7, S_WORK, 15'h1DFF, 8'h00, 0, 1, "R8 mirror top write");
   endtask

   task automatic t_oam();
      acc(16'hFE10, 1, 0, 0, S_NONE, 0, 8'h00, 0, 0, "R9 object read");
      acc(16'hFE9F, 0, 1, 8'hAA, S_NONE, 0, 8'h00, 0, 0, "R9 object write");
   endtask

   task automatic t_hram();
      acc(16'hFF80, 0, 1, 8'h5A, S_NONE, 0, 8'h00, 0, 0, "R10 write low");
      acc(16'hFFFF, 0, 1, 8'hC3, S_NONE, 0, 8'h00, 0, 0, "R10 write high");
      acc(16'hFF80, 1, 0, 0, S_NONE, 0, 8'h5A, 0, 0, "R10 read low");
      acc(16'hFFFF, 1, 0, 0, S_NONE, 0, 8'hC3, 0, 0, "R10 read high");
      acc(16'hFF80, 0, 1, 8'h3E, S_NONE, 0, 8'h00, 0, 0, "R10 overwrite");
      acc(16'hFF80, 1, 0, 0, S_NONE, 0, 8'h3E, 0, 0, "R10 read again");
      acc(16'hFFFF, 1, 0, 0, S_NONE, 0, 8'hC3, 0, 0, "R10 neighbour kept");
   endtask

   task automatic t_io();
      acc(16'hFF00, 1, 0, 0, S_PAD, 15'h0000, 8'hCF, 0, 0, "R11 pad read");
      acc(16'hFF00, 0, 1, 8'h30, S_PAD, 15'h0000, 8'h00, 0, 1, "R11 pad write");
      acc(16'hFF44, 1, 0, 0, S_GFX, 15'h0044, 8'h44 ^ 8'h99, 0, 0, "R11 gfx read");
      acc(16'hFF55, 1, 0, 0, S_GFX, 15'h0055, 8'h55 ^ 8'h99, 0, 0, "R11 gfx read in control group");
      acc(16'hFF47, 0, 1, 8'hE4, S_GFX, 15'h0047, 8'h00, 0, 1, "R11 gfx write");
      acc(16'hFF7F, 0, 1, 8'h01, S_GFX, 15'h007F, 8'h00, 0, 1, "R11 gfx top write");
      acc(16'hFF01, 1, 0, 0, S_NONE, 0, 8'h00, 0, 0, "R12 unknown read");
      acc(16'hFF3F, 1, 0, 0, S_NONE, 0, 8'h00, 0, 0, "R12 unknown read high");
      acc(16'hFF10, 0, 1, 8'h99, S_NONE, 0, 8'h00, 0, 0, "R12 unknown write");
      acc(16'hC000, 0, 0, 0, S_NONE, 0, 8'h00, 0, 0, "R13 no strobe");
   endtask

   initial begin
      t_reset_state();
      t_overlay();
      t_rom_writes();
      t_fetch_clear();
      t_ctl_clear();
      t_video();
      t_rams();
      t_oam();
      t_hram();
      t_io();
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      #40000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule